// File: doc/BRIEF.md
# Paged manufacturer command decoder

This block is the command front end of a display controller. It accepts a byte stream of command packets. A start strobe marks the first byte of a packet and a last flag marks its final byte. Each packet is either a command packet or a continuation packet. A command packet starts with a command byte and carries parameter bytes after it. A continuation packet carries only parameter bytes and keeps filling the register that the previous command opened. Long parameter lists, such as the 52-byte gamma tables, can then arrive as several chunks of up to 15 bytes.

Manufacturer registers stay hidden until an exact unlock packet arrives. That packet is command 0xF0 followed by the key bytes 0x55, 0xAA, 0x52, 0x08 and then a page number, 0 or 1. The selected page decides which register a command code reaches, so one code can name different registers on the two pages. The decoded register contents are driven out continuously as flat vectors for the rest of the controller. The gamma tables are read through a small combinational lookup port. The input is always ready, and no link layer, checksum or read-back exists here.

Top module: `mfr_cmd_decoder`

## Requirements
- R1: A command packet with code 0xF0 unlocks the block when it ends and carries exactly five parameters: 0x55, 0xAA, 0x52, 0x08, then a page byte of 0 or 1. After that packet, `unlocked` is 1 and `page_sel` equals the page byte. Both are visible from the clock edge that accepts the last byte.
- R2: Some 0xF0 packets end with a different parameter list: a wrong key byte, fewer or more than five parameters, or a page byte above 1. Such a packet leaves `unlocked` at 0 and `page_sel` at 0.
- R3: On page 0, these codes write registers with the following lengths and byte addresses in `p0_regs`. Byte k of `p0_regs` sits at bits [8k+7:8k].

  | Code | Length | Addresses |
  |---|---|---|
  | 0xB1 | 2 | 0-1 |
  | 0xB7 | 2 | 2-3 |
  | 0xB8 | 4 | 4-7 |
  | 0xBA | 1 | 8 |
  | 0xBD | 5 | 9-13 |
  | 0xBE | 5 | 14-18 |
  | 0xBF | 5 | 19-23 |
  | 0xCC | 3 | 24-26 |

  Parameter i lands at the register's first address plus i. It appears on the outputs one cycle after it is accepted.
- R4: On page 1, these codes write registers in `p1_regs`. Byte k of `p1_regs` sits at bits [8k+7:8k].

  | Code | Length | Bytes |
  |---|---|---|
  | 0xB0 | 3 | 0-2 |
  | 0xB1 | 3 | 3-5 |
  | 0xB3 | 3 | 6-8 |
  | 0xB5 | 3 | 9-11 |
  | 0xB6 | 3 | 12-14 |
  | 0xB7 | 3 | 15-17 |
  | 0xB9 | 3 | 18-20 |
  | 0xBA | 3 | 21-23 |
  | 0xBC | 3 | 24-26 |
  | 0xBD | 3 | 27-29 |
  | 0xBF | 1 | 30 |
- R5: On page 1, codes 0xD1 to 0xD6 each write a 52-byte gamma table. The tables are, in order, red, green and blue positive, then red, green and blue negative. `gamma_byte` returns table `gamma_sel` (0 to 5, mapping to 0xD1 to 0xD6) at index `gamma_idx`. It returns 0 when either value is out of range.
- R6: A continuation packet is a packet whose start byte has `in_cont` = 1. Its bytes continue the register opened by the last command packet, from the position where the earlier bytes stopped.
- R7: Parameter bytes beyond a register's length are dropped and set `overflow`. `overflow` stays at 1 until reset.
- R8: Some bytes write nothing and leave `overflow` unchanged:
  - manufacturer codes received while locked;
  - codes unknown on the current page;
  - continuation bytes with no open register;
  - the parameters of a 0xF0 packet.
- R9: Code 0xB1 writes `p0_regs` bytes 0-1 on page 0 and `p1_regs` bytes 3-5 on page 1. A write on one page leaves the other page's register unchanged.
- R10: `disp_opt[5:0]` carries bits 7..2 of page-0 register 0xB1 byte 0, in this order from bit 5 down to bit 0:
  - keep RAM in sleep;
  - tear-effect enable;
  - generic access enable;
  - video mode;
  - end-of-transmission packet enable;
  - pixel format.
- R11: After reset, the block is locked with `page_sel` = 0 and `overflow` = 0. Every register byte is 0 except the following defaults:
  - page-0 0xB8 holds 01 07 07 07;
  - page-0 0xBD, 0xBE and 0xBF each start 01 84;
  - page-1 0xB0 and 0xB1 each hold 05 05 05;
  - page-1 0xB3 and 0xB5 each hold 08 08 08;
  - page-1 0xB6 holds 44 44 44;
  - page-1 0xB7 and 0xB9 each hold 34 34 34;
  - page-1 0xBA holds 32 32 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_ready | output | 1 | Always 1; every valid byte is taken |
| in_start | input | 1 | First byte of a packet |
| in_cont | input | 1 | With `in_start`: packet is a continuation with no command byte |
| in_last | input | 1 | Final byte of the packet |
| in_data | input | 8 | Command or parameter byte |
| unlocked | output | 1 | Manufacturer commands enabled |
| page_sel | output | 1 | Selected manufacturer page |
| overflow | output | 1 | Sticky: a parameter beyond a register's length was dropped |
| p0_regs | output | 216 | Page-0 register bytes |
| p1_regs | output | 248 | Page-1 control register bytes |
| disp_opt | output | 6 | Option bits of page-0 register 0xB1 byte 0 |
| gamma_sel | input | 3 | Gamma table select |
| gamma_idx | input | 6 | Gamma byte index |
| gamma_byte | output | 8 | Selected gamma byte |

## Verification
The bench targets unlock packets that are almost right: one key byte wrong, four or six parameters, or a page byte of 2 or more. A decoder that compares too loosely would open the pages on those packets. The bench also writes 0xB1 on both pages to catch a table that ignores the page, and splits gamma tables into 15-byte chunks with an extra continuation packet. A pointer that restarts at each packet would overwrite the start of the table. Finally, it sends more bytes than a register holds and manufacturer codes while locked. A design that wraps the address or writes when locked would corrupt a neighbouring register, and one that clears the flag would lose the overflow indication.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int BYTE_W       = 8;
  localparam int P0_BYTES     = 27;
  localparam int P1_CTL_BYTES = 31;
  localparam int GAMMA_LEN    = 52;
  localparam int GAMMA_TABLES = 6;
  localparam int P1_BASE      = P0_BYTES;
  localparam int GAMMA_BASE   = P0_BYTES + P1_CTL_BYTES;
  localparam int TOTAL        = GAMMA_BASE + GAMMA_TABLES * GAMMA_LEN;
  localparam int ADDR_W       = $clog2(TOTAL);
  localparam int LEN_W        = $clog2(GAMMA_LEN + 1);
  localparam int KEY_LEN      = 4;
  localparam logic [BYTE_W-1:0] CMD_UNLOCK = 8'hF0;
  localparam logic [BYTE_W-1:0] CMD_GAMMA0 = 8'hD1;

  typedef struct packed {
    logic              hit;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  len;
  } slot_t;

  function automatic slot_t mk_slot(input int b, input int l);
    slot_t s;
    s.hit  = 1'b1;
    s.base = ADDR_W'(b);
    s.len  = LEN_W'(l);
    return s;
  endfunction

  // Register table: page and code select a byte range of the unified store.
  function automatic slot_t find_slot(input logic pg, input logic [BYTE_W-1:0] code);
    slot_t s;
    s = '0;
    if (!pg) begin
      case (code)
        8'hB1:   s = mk_slot(0, 2);
        8'hB7:   s = mk_slot(2, 2);
        8'hB8:   s = mk_slot(4, 4);
        8'hBA:   s = mk_slot(8, 1);
        8'hBD:   s = mk_slot(9, 5);
        8'hBE:   s = mk_slot(14, 5);
        8'hBF:   s = mk_slot(19, 5);
        8'hCC:   s = mk_slot(24, 3);
        default: s = '0;
      endcase
    end else begin
      case (code)
        8'hB0:   s = mk_slot(P1_BASE + 0, 3);
        8'hB1:   s = mk_slot(P1_BASE + 3, 3);
        8'hB3:   s = mk_slot(P1_BASE + 6, 3);
        8'hB5:   s = mk_slot(P1_BASE + 9, 3);
        8'hB6:   s = mk_slot(P1_BASE + 12, 3);
        8'hB7:   s = mk_slot(P1_BASE + 15, 3);
        8'hB9:   s = mk_slot(P1_BASE + 18, 3);
        8'hBA:   s = mk_slot(P1_BASE + 21, 3);
        8'hBC:   s = mk_slot(P1_BASE + 24, 3);
        8'hBD:   s = mk_slot(P1_BASE + 27, 3);
        8'hBF:   s = mk_slot(P1_BASE + 30, 1);
        8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hD5, 8'hD6:
          s = mk_slot(GAMMA_BASE + int'(code - CMD_GAMMA0) * GAMMA_LEN, GAMMA_LEN);
        default: s = '0;
      endcase
    end
    return s;
  endfunction

  function automatic logic [BYTE_W-1:0] unlock_key(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h55;
      3'd1:    return 8'hAA;
      3'd2:    return 8'h52;
      3'd3:    return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit in_rng(input int a, input int b, input int n);
    return (a >= b) && (a < b + n);
  endfunction

  function automatic logic [BYTE_W-1:0] reg_default(input int a);
    if (a == 4)                          return 8'h01;
    if (in_rng(a, 5, 3))                 return 8'h07;
    if (a == 9 || a == 14 || a == 19)    return 8'h01;
    if (a == 10 || a == 15 || a == 20)   return 8'h84;
    if (in_rng(a, P1_BASE + 0, 6))       return 8'h05;
    if (in_rng(a, P1_BASE + 6, 6))       return 8'h08;
    if (in_rng(a, P1_BASE + 12, 3))      return 8'h44;
    if (in_rng(a, P1_BASE + 15, 6))      return 8'h34;
    if (in_rng(a, P1_BASE + 21, 3))      return 8'h32;
    return 8'h00;
  endfunction

  function automatic logic [ADDR_W-1:0] gamma_addr(input logic [2:0] sel, input logic [5:0] idx);
    return ADDR_W'(GAMMA_BASE + int'(sel) * GAMMA_LEN + int'(idx));
  endfunction
endpackage

// File: rtl/mcd_unlock.sv
module mcd_unlock
  import mcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_begin,
  input  logic              seq_byte,
  input  logic              seq_last,
  input  logic [BYTE_W-1:0] seq_data,
  output logic              unlocked,
  output logic              page_sel,
  output logic              seq_commit,
  output logic              seq_fail
);
  logic [2:0] idx;
  logic       match;
  logic       byte_ok;

  always_comb begin
    if (idx < 3'(KEY_LEN))       byte_ok = (seq_data == unlock_key(idx));
    else if (idx == 3'(KEY_LEN)) byte_ok = (seq_data <= 8'd1);
    else                         byte_ok = 1'b0;
  end

  assign seq_commit = seq_byte && seq_last && match && byte_ok && (idx == 3'(KEY_LEN));
  assign seq_fail   = (seq_begin && seq_last) || (seq_byte && seq_last && !seq_commit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      match    <= 1'b0;
      unlocked <= 1'b0;
      page_sel <= 1'b0;
    end else begin
      if (seq_begin) begin
        idx   <= '0;
        match <= 1'b1;
      end else if (seq_byte) begin
        if (idx != 3'(KEY_LEN + 1)) idx <= idx + 3'd1;
        match <= match && byte_ok;
      end
      if (seq_commit) begin
        unlocked <= 1'b1;
        page_sel <= seq_data[0];
      end else if (seq_fail) begin
        unlocked <= 1'b0;
        page_sel <= 1'b0;
      end
    end
  end

  AST_UNLOCK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(seq_byte && seq_last)); // R1
  AST_FAIL_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fail |=> (!unlocked && !page_sel)); // R2
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_commit && !seq_fail) |=> $stable(page_sel) && $stable(unlocked)); // R1
endmodule

// File: rtl/mcd_parser.sv
module mcd_parser
  import mcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic              in_cont,
  input  logic              in_last,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              unlocked,
  input  logic              page_sel,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              ovf,
  output logic              seq_begin,
  output logic              seq_byte,
  output logic              seq_last
);
  logic              in_pkt;
  logic              is_f0;
  logic              tgt_hit;
  logic [ADDR_W-1:0] tgt_base;
  logic [LEN_W-1:0]  tgt_len;
  logic [LEN_W-1:0]  ptr;

  logic  cmd_byte, cont_start, mid_byte, data_byte, live, ovf_set;
  slot_t slot_now;

  assign cmd_byte   = in_valid && in_start && !in_cont;
  assign cont_start = in_valid && in_start && in_cont;
  assign mid_byte   = in_valid && !in_start && in_pkt;
  assign data_byte  = cont_start || (mid_byte && !is_f0);
  assign live       = data_byte && tgt_hit && unlocked;
  assign wr_en      = live && (ptr < tgt_len);
  assign ovf_set    = live && (ptr >= tgt_len);
  assign wr_addr    = tgt_base + ADDR_W'(ptr);
  assign wr_data    = in_data;
  assign slot_now   = find_slot(page_sel, in_data);

  assign seq_begin  = cmd_byte && (in_data == CMD_UNLOCK);
  assign seq_byte   = mid_byte && is_f0;
  assign seq_last   = in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      is_f0    <= 1'b0;
      tgt_hit  <= 1'b0;
      tgt_base <= '0;
      tgt_len  <= '0;
      ptr      <= '0;
      ovf      <= 1'b0;
    end else begin
      if (cmd_byte) begin
        in_pkt   <= !in_last;
        is_f0    <= (in_data == CMD_UNLOCK);
        tgt_hit  <= (in_data != CMD_UNLOCK) && unlocked && slot_now.hit;
        tgt_base <= slot_now.base;
        tgt_len  <= slot_now.len;
        ptr      <= '0;
      end else if (cont_start || mid_byte) begin
        in_pkt <= !in_last;
        if (cont_start) is_f0 <= 1'b0;
        if (wr_en) ptr <= ptr + LEN_W'(1);
      end
      if (ovf_set) ovf <= 1'b1;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R7
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < TOTAL)); // R3
  AST_NO_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> unlocked); // R8
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_hit |-> (ptr <= tgt_len)); // R7
endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile
  import mcd_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            waddr,
  input  logic [BYTE_W-1:0]            wdata,
  output logic [P0_BYTES*BYTE_W-1:0]   p0_flat,
  output logic [P1_CTL_BYTES*BYTE_W-1:0] p1_flat,
  input  logic [2:0]                   gamma_sel,
  input  logic [5:0]                   gamma_idx,
  output logic [BYTE_W-1:0]            gamma_byte
);
  logic [BYTE_W-1:0] mem [TOTAL];
  logic              gvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < TOTAL; a++) mem[a] <= reg_default(a);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar k = 0; k < P0_BYTES; k++) begin : g_p0
    assign p0_flat[k*BYTE_W +: BYTE_W] = mem[k];
  end
  for (genvar k = 0; k < P1_CTL_BYTES; k++) begin : g_p1
    assign p1_flat[k*BYTE_W +: BYTE_W] = mem[P1_BASE + k];
  end

  assign gvalid     = (int'(gamma_sel) < GAMMA_TABLES) && (int'(gamma_idx) < GAMMA_LEN);
  assign gamma_byte = gvalid ? mem[gamma_addr(gamma_sel, gamma_idx)] : '0;

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(p0_flat) && $stable(p1_flat))); // R8
endmodule

// File: rtl/mfr_cmd_decoder.sv
module mfr_cmd_decoder
  import mcd_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic                           in_start,
  input  logic                           in_cont,
  input  logic                           in_last,
  input  logic [BYTE_W-1:0]              in_data,
  output logic                           unlocked,
  output logic                           page_sel,
  output logic                           overflow,
  output logic [P0_BYTES*BYTE_W-1:0]     p0_regs,
  output logic [P1_CTL_BYTES*BYTE_W-1:0] p1_regs,
  output logic [5:0]                     disp_opt,
  input  logic [2:0]                     gamma_sel,
  input  logic [5:0]                     gamma_idx,
  output logic [BYTE_W-1:0]              gamma_byte
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic              seq_begin, seq_byte, seq_last, seq_commit, seq_fail;

  assign in_ready = 1'b1;

  mcd_parser u_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_cont(in_cont), .in_last(in_last), .in_data(in_data),
    .unlocked(unlocked), .page_sel(page_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ovf(overflow),
    .seq_begin(seq_begin), .seq_byte(seq_byte), .seq_last(seq_last)
  );

  mcd_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .seq_begin(seq_begin), .seq_byte(seq_byte),
    .seq_last(seq_last), .seq_data(in_data), .unlocked(unlocked),
    .page_sel(page_sel), .seq_commit(seq_commit), .seq_fail(seq_fail)
  );

  mcd_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .p0_flat(p0_regs), .p1_flat(p1_regs),
    .gamma_sel(gamma_sel), .gamma_idx(gamma_idx), .gamma_byte(gamma_byte)
  );

  // Option bits live in byte 0, bits 7..2, of page-0 register 0xB1.
  assign disp_opt = p0_regs[7:2];

  AST_COMMIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_commit && seq_fail)); // R2
  AST_UNLOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_byte |-> !wr_en); // R8
endmodule

// File: tb/mfr_cmd_decoder_test.sv
`timescale 1ns/1ps
module mfr_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, in_cont = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, unlocked, page_sel, overflow;
  logic [215:0] p0_regs;
  logic [247:0] p1_regs;
  logic [5:0] disp_opt;
  logic [2:0] gamma_sel = 3'd0;
  logic [5:0] gamma_idx = 6'd0;
  logic [7:0] gamma_byte;

  always #5 clk = ~clk;

  mfr_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_cont(in_cont), .in_last(in_last), .in_data(in_data),
    .unlocked(unlocked), .page_sel(page_sel), .overflow(overflow),
    .p0_regs(p0_regs), .p1_regs(p1_regs), .disp_opt(disp_opt),
    .gamma_sel(gamma_sel), .gamma_idx(gamma_idx), .gamma_byte(gamma_byte)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  // Bench model of the register store, laid out as in R3/R4/R5.
  logic [7:0] mm [370];
  bit m_unl, m_pg, m_ovf, m_hit;
  int m_base, m_len, m_ptr;
  logic [7:0] bb [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_dflt(input int a);
    logic [7:0] v;
    v = 8'h00;
    if (a == 4) v = 8'h01;
    if (a >= 5 && a <= 7) v = 8'h07;
    if (a == 9 || a == 14 || a == 19) v = 8'h01;
    if (a == 10 || a == 15 || a == 20) v = 8'h84;
    if (a >= 27 && a <= 32) v = 8'h05;
    if (a >= 33 && a <= 38) v = 8'h08;
    if (a >= 39 && a <= 41) v = 8'h44;
    if (a >= 42 && a <= 47) v = 8'h34;
    if (a >= 48 && a <= 50) v = 8'h32;
    return v;
  endfunction

  function automatic void tb_find(input bit pg, input logic [7:0] code,
                                  output bit hit, output int base, output int len);
    int c0 [8]  = '{'hB1, 'hB7, 'hB8, 'hBA, 'hBD, 'hBE, 'hBF, 'hCC};
    int l0 [8]  = '{2, 2, 4, 1, 5, 5, 5, 3};
    int c1 [17] = '{'hB0, 'hB1, 'hB3, 'hB5, 'hB6, 'hB7, 'hB9, 'hBA, 'hBC, 'hBD, 'hBF,
                    'hD1, 'hD2, 'hD3, 'hD4, 'hD5, 'hD6};
    int l1 [17] = '{3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 1, 52, 52, 52, 52, 52, 52};
    int acc;
    hit = 0; base = 0; len = 0;
    if (!pg) begin
      acc = 0;
      for (int i = 0; i < 8; i++) begin
        if (int'(code) == c0[i]) begin hit = 1; base = acc; len = l0[i]; end
        acc += l0[i];
      end
    end else begin
      acc = 27;
      for (int i = 0; i < 17; i++) begin
        if (int'(code) == c1[i]) begin hit = 1; base = acc; len = l1[i]; end
        acc += l1[i];
      end
    end
  endfunction

  function automatic void model_data(input logic [7:0] d);
    if (m_unl && m_hit) begin
      if (m_ptr < m_len) begin mm[m_base + m_ptr] = d; m_ptr++; end
      else m_ovf = 1;
    end
  endfunction

  task automatic put(input bit s, input bit c, input bit l, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1; in_start = s; in_cont = c; in_last = l; in_data = d;
    @(posedge clk);
  endtask

  task automatic send_write(input logic [7:0] cmd, input int n);
    int sent, k;
    bit h; int b, l;
    put(1, 0, n == 0, cmd);
    k = (n > 15) ? 15 : n;
    for (int i = 0; i < k; i++) put(0, 0, i == k - 1, bb[i]);
    sent = k;
    while (sent < n) begin
      k = (n - sent > 15) ? 15 : n - sent;
      for (int i = 0; i < k; i++) put(i == 0, i == 0, i == k - 1, bb[sent + i]);
      sent += k;
    end
    tb_find(m_pg, cmd, h, b, l);
    m_hit = m_unl && h; m_base = b; m_len = l; m_ptr = 0;
    for (int i = 0; i < n; i++) model_data(bb[i]);
  endtask

  task automatic send_cont(input int n);
    for (int i = 0; i < n; i++) put(i == 0, i == 0, i == n - 1, bb[i]);
    for (int i = 0; i < n; i++) model_data(bb[i]);
  endtask

  task automatic send_f0(input int n);
    bit ok;
    put(1, 0, n == 0, 8'hF0);
    for (int i = 0; i < n; i++) put(0, 0, i == n - 1, bb[i]);
    ok = (n == 5) && bb[0] == 8'h55 && bb[1] == 8'hAA && bb[2] == 8'h52 &&
         bb[3] == 8'h08 && bb[4] <= 8'd1;
    m_hit = 0;
    if (ok) begin m_unl = 1; m_pg = bb[4][0]; end
    else begin m_unl = 0; m_pg = 0; end
  endtask

  task automatic load_key(input logic [7:0] pg);
    bb[0] = 8'h55; bb[1] = 8'hAA; bb[2] = 8'h52; bb[3] = 8'h08; bb[4] = pg;
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 0; in_start = 0; in_cont = 0; in_last = 0;
    #1;
  endtask

  task automatic check_state(input string req);
    logic [215:0] e0;
    logic [247:0] e1;
    for (int k = 0; k < 27; k++) e0[8*k +: 8] = mm[k];
    for (int k = 0; k < 31; k++) e1[8*k +: 8] = mm[27 + k];
    chk(p0_regs == e0, req, "p0_regs", 256'(p0_regs), 256'(e0));
    chk(p1_regs == e1, req, "p1_regs", 256'(p1_regs), 256'(e1));
    chk(unlocked == m_unl && page_sel == m_pg, req, "unlock/page",
        256'({unlocked, page_sel}), 256'({m_unl, m_pg}));
    chk(overflow == m_ovf, req, "overflow", 256'(overflow), 256'(m_ovf));
    chk(disp_opt == mm[0][7:2], "R10", "disp_opt", 256'(disp_opt), 256'(mm[0][7:2]));
  endtask

  task automatic check_gamma(input string req);
    for (int s = 0; s < 7; s++) begin
      bit ok; logic [7:0] a, e;
      ok = 1; a = 0; e = 0;
      for (int i = 0; i < 54; i++) begin
        logic [7:0] x;
        @(negedge clk);
        gamma_sel = 3'(s); gamma_idx = 6'(i);
        #1;
        x = (s < 6 && i < 52) ? mm[58 + s * 52 + i] : 8'h00;
        if (ok && gamma_byte !== x) begin ok = 0; a = gamma_byte; e = x; end
      end
      chk(ok, req, $sformatf("gamma table %0d", s), 256'(a), 256'(e));
    end
  endtask

  initial begin
    #(1500000 * 10);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int a = 0; a < 370; a++) mm[a] = tb_dflt(a);
    m_unl = 0; m_pg = 0; m_ovf = 0; m_hit = 0; m_base = 0; m_len = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();

    // R11: reset state
    chk(p1_regs[23:0] == 24'h050505, "R11", "AVDD default", 256'(p1_regs[23:0]), 256'h050505);
    chk(p0_regs[63:32] == 32'h07070701, "R11", "0xB8 default", 256'(p0_regs[63:32]), 256'h07070701);
    chk(!unlocked && !overflow, "R11", "flags", 256'({unlocked, overflow}), 256'd0);
    check_state("R11");
    check_gamma("R11");

    // R8: manufacturer code while locked
    for (int i = 0; i < 4; i++) bb[i] = 8'hE0 + 8'(i);
    send_write(8'hB8, 4); settle(); check_state("R8");
    chk(p0_regs[39:32] == 8'h01, "R8", "locked write ignored", 256'(p0_regs[39:32]), 256'h01);

    // R2: near-miss unlock packets
    load_key(8'h00); bb[2] = 8'h53; send_f0(5); settle(); check_state("R2");
    load_key(8'h00); send_f0(4); settle(); check_state("R2");
    load_key(8'h01); bb[5] = 8'h00; send_f0(6); settle(); check_state("R2");
    load_key(8'h02); send_f0(5); settle(); check_state("R2");
    chk(!unlocked, "R2", "page 2 rejected", 256'(unlocked), 256'd0);

    // R1, R3, R10, R9: page 0
    load_key(8'h00); send_f0(5); settle(); check_state("R1");
    chk(unlocked && !page_sel, "R1", "page0 unlocked", 256'({unlocked, page_sel}), 256'b10);
    bb[0] = 8'hAA; bb[1] = 8'hBB; send_write(8'hB1, 2); settle(); check_state("R3");
    chk(disp_opt == 6'b101010, "R10", "option bits", 256'(disp_opt), 256'b101010);
    for (int i = 0; i < 5; i++) bb[i] = 8'h30 + 8'(i);
    send_write(8'hBE, 5); settle(); check_state("R3");
    chk(p0_regs[14*8 +: 8] == 8'h30, "R3", "0xBE byte0", 256'(p0_regs[14*8 +: 8]), 256'h30);

    // R7: overflow
    bb[0] = 8'h11; bb[1] = 8'h22; bb[2] = 8'h33; send_write(8'hBA, 3); settle(); check_state("R7");
    chk(overflow && p0_regs[71:64] == 8'h11 && p0_regs[79:72] == 8'h01, "R7", "drop+flag",
        256'({overflow, p0_regs[79:64]}), 256'({1'b1, 16'h0111}));

    // R9, R4: page 1
    load_key(8'h01); send_f0(5); settle(); check_state("R1");
    bb[0] = 8'h11; bb[1] = 8'h22; bb[2] = 8'h33; send_write(8'hB1, 3); settle(); check_state("R4");
    chk(p1_regs[47:24] == 24'h332211 && p0_regs[15:0] == 16'hBBAA, "R9", "0xB1 per page",
        256'({p1_regs[47:24], p0_regs[15:0]}), 256'({24'h332211, 16'hBBAA}));

    // R5, R6: gamma split into chunks, then extended by a continuation
    for (int i = 0; i < 20; i++) bb[i] = 8'h80 + 8'(i);
    send_write(8'hD1, 20);
    for (int i = 0; i < 10; i++) bb[i] = 8'hC0 + 8'(i);
    send_cont(10); settle(); check_state("R6");
    gamma_sel = 3'd0; gamma_idx = 6'd25; #1;
    chk(gamma_byte == 8'hC5, "R6", "continued byte", 256'(gamma_byte), 256'hC5);
    for (int i = 0; i < 52; i++) bb[i] = 8'(i * 7 + 3);
    send_write(8'hD6, 52); settle(); check_gamma("R5");

    // R8: unknown code on page 1, and bad unlock then write
    bb[0] = 8'h99; send_write(8'hC0, 1); settle(); check_state("R8");
    load_key(8'h01); bb[4] = 8'h05; send_f0(5); settle();
    bb[0] = 8'h77; bb[1] = 8'h77; bb[2] = 8'h77; send_write(8'hB0, 3); settle(); check_state("R8");

    // Random mix
    for (int it = 0; it < 150; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 2) begin
        load_key(8'($urandom % 2)); send_f0(5); settle(); check_state("R1");
      end else if (r == 2) begin
        int md;
        md = int'($urandom % 4);
        load_key(8'($urandom % 2));
        if (md == 0) begin bb[$urandom % 4] ^= 8'h01 + 8'($urandom % 200); send_f0(5); end
        else if (md == 1) send_f0(4);
        else if (md == 2) begin bb[5] = 8'($urandom); send_f0(6); end
        else begin bb[4] = 8'd2 + 8'($urandom % 250); send_f0(5); end
        settle(); check_state("R2");
      end else if (r == 3) begin
        int n;
        n = 1 + int'($urandom % 20);
        for (int i = 0; i < n; i++) bb[i] = 8'($urandom);
        send_cont(n); settle(); check_state("R6");
      end else begin
        logic [7:0] code;
        bit h; int b, l, n;
        int cl [18] = '{'hB0, 'hB1, 'hB3, 'hB5, 'hB6, 'hB7, 'hB8, 'hB9, 'hBA, 'hBC,
                        'hBD, 'hBE, 'hBF, 'hCC, 'hD1, 'hD3, 'hD5, 'hC4};
        code = 8'(cl[$urandom % 18]);
        tb_find(m_pg, code, h, b, l);
        n = int'($urandom % ((h ? l : 2) + 3));
        for (int i = 0; i < n; i++) bb[i] = 8'($urandom);
        send_write(code, n); settle();
        check_state(m_pg ? "R4" : "R3");
      end
      if (it % 50 == 49) check_gamma("R5");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule